// File: doc/BRIEF.md
# Dual-Port Video Frame Buffer

The block is a one-bit-per-pixel frame store arranged as a square grid of rows and columns (256 by 256 by default). A host reaches any single pixel through a random-access port that addresses it by row and column. A display pipeline reads whole scan lines through a serial port instead: a transfer request copies one complete row into a shift register, and the register then emits one pixel per enabled clock, column 0 first.

Once the shift register is loaded, it drains on its own. The random port keeps working while it drains, and a write to the row being streamed does not change the pixels already captured. A rectangle-fill command sets every pixel inside an inclusive row and column range to 0 or to 1. It writes one masked row per clock, so the host does not have to write each pixel. While a fill runs, the block raises busy. During that time random accesses and transfer loads are held off.

Top module: `fb_video_buf`

## Requirements
- R1: A random write (acc_en_i=1, acc_we_i=1) accepted while busy_o=0 stores acc_wdata_i at (acc_row_i, acc_col_i). A read (acc_en_i=1, acc_we_i=0) accepted while busy_o=0 presents the stored bit on acc_rdata_o at the next clock edge. acc_rdata_o holds its value in every other cycle.
- R2: A transfer load copies the whole requested row into the shift register. After the load, video_o shows column 0. Each cycle in which shift_en_i=1 and the register is not empty moves video_o to the next column.
- R3: shift_empty_o is 1 after reset and becomes 1 again after 256 enabled shifts. video_o is 0 whenever shift_empty_o is 1.
- R4: A transfer request (xfer_req_i=1) sets a pending request for xfer_row_i. The pending request loads on the first edge at which the register is empty and busy_o=0. A request made while another is still pending is ignored.
- R5: Random writes made after a load, including writes to the row being streamed, do not change the bits being shifted out.
- R6: A fill sets every bit in rows fill_row0_i..fill_row1_i and columns fill_col0_i..fill_col1_i (all bounds inclusive) to fill_val_i. Bits outside that region keep their values.
- R7: A fill start accepted while busy_o=0 with valid bounds raises busy_o from the next cycle, for exactly fill_row1_i-fill_row0_i+1 cycles.
- R8: While busy_o=1, random accesses are ignored, pending transfers do not load, and further fill starts are ignored.
- R9: A fill start with row0>row1 or col0>col1 leaves busy_o low and changes no bit.
- R10: Reset drives busy_o=0, shift_empty_o=1, video_o=0 and acc_rdata_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_en_i | input | 1 | Random-port access strobe |
| acc_we_i | input | 1 | 1 = write, 0 = read |
| acc_row_i | input | 8 | Random-port row |
| acc_col_i | input | 8 | Random-port column |
| acc_wdata_i | input | 1 | Write data |
| acc_rdata_o | output | 1 | Registered read data |
| fill_start_i | input | 1 | Fill command strobe |
| fill_row0_i | input | 8 | First row of the fill |
| fill_row1_i | input | 8 | Last row of the fill |
| fill_col0_i | input | 8 | First column of the fill |
| fill_col1_i | input | 8 | Last column of the fill |
| fill_val_i | input | 1 | Fill value |
| busy_o | output | 1 | Fill in progress |
| xfer_req_i | input | 1 | Row-transfer request |
| xfer_row_i | input | 8 | Row to transfer |
| shift_en_i | input | 1 | Pixel-clock enable for the serial port |
| shift_empty_o | output | 1 | Shift register drained |
| video_o | output | 1 | Serial pixel output |

## Verification
The fill is tried with a whole-frame clear, with a narrow multi-row rectangle whose corners and edge neighbours are read back, and with bounds reversed in rows and then in columns. Together these show whether the range compare is inclusive and whether a bad command does nothing. Streaming is tried with shift enables that come in gaps, with the streamed row overwritten during the drain, and with a second transfer queued mid-stream plus a third request that should be ignored. This shows capture-time snapshotting, apart from both queueing and dropping. A fill started while a transfer is pending shows that the load is stalled, not lost.

// File: rtl/fb_pkg.sv
package fb_pkg;
  localparam int unsigned FB_ROWS = 256;
  localparam int unsigned FB_COLS = 256;

  typedef enum logic [1:0] {
    WSRC_NONE = 2'd0,
    WSRC_HOST = 2'd1,
    WSRC_FILL = 2'd2
  } wsrc_e;
endpackage

// File: rtl/fb_array.sv
module fb_array #(
  parameter int unsigned ROWS = 256,
  parameter int unsigned COLS = 256,
  localparam int unsigned RW = $clog2(ROWS)
) (
  input  logic            clk_i,
  input  logic            we_i,
  input  logic [RW-1:0]   wrow_i,
  input  logic [COLS-1:0] wmask_i,
  input  logic            wval_i,
  input  logic [RW-1:0]   xrow_i,
  output logic [COLS-1:0] xdata_o,
  input  logic [RW-1:0]   arow_i,
  output logic [COLS-1:0] adata_o
);
  logic [COLS-1:0] mem_q [ROWS];

  always_ff @(posedge clk_i) begin
    if (we_i)
      mem_q[wrow_i] <= (mem_q[wrow_i] & ~wmask_i) | (wval_i ? wmask_i : '0);
  end

  assign xdata_o = mem_q[xrow_i];
  assign adata_o = mem_q[arow_i];
endmodule

// File: rtl/fb_fill_seq.sv
module fb_fill_seq #(
  parameter int unsigned ROWS = 256,
  parameter int unsigned COLS = 256,
  localparam int unsigned RW = $clog2(ROWS),
  localparam int unsigned CW = $clog2(COLS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [RW-1:0]   row0_i,
  input  logic [RW-1:0]   row1_i,
  input  logic [CW-1:0]   col0_i,
  input  logic [CW-1:0]   col1_i,
  input  logic            val_i,
  output logic            busy_o,
  output logic [RW-1:0]   wrow_o,
  output logic [COLS-1:0] wmask_o,
  output logic            wval_o
);
  logic          active_q, val_q;
  logic [RW-1:0] cur_q, last_q;
  logic [CW-1:0] c0_q, c1_q;
  logic          accept;

  assign accept = start_i && !active_q && (row0_i <= row1_i) && (col0_i <= col1_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      val_q    <= 1'b0;
      cur_q    <= '0;
      last_q   <= '0;
      c0_q     <= '0;
      c1_q     <= '0;
    end else if (accept) begin
      active_q <= 1'b1;
      cur_q    <= row0_i;
      last_q   <= row1_i;
      c0_q     <= col0_i;
      c1_q     <= col1_i;
      val_q    <= val_i;
    end else if (active_q) begin
      if (cur_q == last_q) active_q <= 1'b0;
      else                 cur_q    <= cur_q + 1'b1;
    end
  end

  for (genvar g = 0; g < COLS; g++) begin : g_mask
    localparam logic [CW-1:0] GC = CW'(g);
    assign wmask_o[g] = active_q && (GC >= c0_q) && (GC <= c1_q);
  end

  assign busy_o = active_q;
  assign wrow_o = cur_q;
  assign wval_o = val_q;
endmodule

// File: rtl/fb_shift_out.sv
module fb_shift_out #(
  parameter int unsigned COLS = 256,
  localparam int unsigned NW = $clog2(COLS + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [COLS-1:0] row_i,
  input  logic            shift_i,
  output logic            empty_o,
  output logic            bit_o
);
  logic [COLS-1:0] sh_q;
  logic [NW-1:0]   left_q;

  assign empty_o = (left_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load_i) begin
      sh_q   <= row_i;
      left_q <= NW'(COLS);
    end else if (shift_i && !empty_o) begin
      sh_q   <= sh_q >> 1;
      left_q <= left_q - 1'b1;
    end
  end

  assign bit_o = !empty_o && sh_q[0];
endmodule

// File: rtl/fb_video_buf.sv
module fb_video_buf #(
  parameter int unsigned ROWS = fb_pkg::FB_ROWS,
  parameter int unsigned COLS = fb_pkg::FB_COLS,
  localparam int unsigned RW = $clog2(ROWS),
  localparam int unsigned CW = $clog2(COLS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_en_i,
  input  logic          acc_we_i,
  input  logic [RW-1:0] acc_row_i,
  input  logic [CW-1:0] acc_col_i,
  input  logic          acc_wdata_i,
  output logic          acc_rdata_o,
  input  logic          fill_start_i,
  input  logic [RW-1:0] fill_row0_i,
  input  logic [RW-1:0] fill_row1_i,
  input  logic [CW-1:0] fill_col0_i,
  input  logic [CW-1:0] fill_col1_i,
  input  logic          fill_val_i,
  output logic          busy_o,
  input  logic          xfer_req_i,
  input  logic [RW-1:0] xfer_row_i,
  input  logic          shift_en_i,
  output logic          shift_empty_o,
  output logic          video_o
);
  import fb_pkg::*;

  logic [RW-1:0]   f_row;
  logic [COLS-1:0] f_mask;
  logic            f_val;
  logic            pend_q;
  logic [RW-1:0]   prow_q;
  logic            load;
  wsrc_e           wsrc;
  logic            we;
  logic [RW-1:0]   wrow;
  logic [COLS-1:0] wmask;
  logic            wval;
  logic [COLS-1:0] xdata, adata;
  logic            rd_acc;

  fb_fill_seq #(.ROWS(ROWS), .COLS(COLS)) u_fill (
    .clk_i, .rst_ni,
    .start_i(fill_start_i), .row0_i(fill_row0_i), .row1_i(fill_row1_i),
    .col0_i(fill_col0_i), .col1_i(fill_col1_i), .val_i(fill_val_i),
    .busy_o, .wrow_o(f_row), .wmask_o(f_mask), .wval_o(f_val)
  );

  always_comb begin
    if (busy_o)                   wsrc = WSRC_FILL;
    else if (acc_en_i && acc_we_i) wsrc = WSRC_HOST;
    else                          wsrc = WSRC_NONE;
  end

  assign we    = (wsrc != WSRC_NONE);
  assign wrow  = (wsrc == WSRC_FILL) ? f_row  : acc_row_i;
  assign wmask = (wsrc == WSRC_FILL) ? f_mask : (COLS'(1) << acc_col_i);
  assign wval  = (wsrc == WSRC_FILL) ? f_val  : acc_wdata_i;

  fb_array #(.ROWS(ROWS), .COLS(COLS)) u_array (
    .clk_i, .we_i(we), .wrow_i(wrow), .wmask_i(wmask), .wval_i(wval),
    .xrow_i(prow_q), .xdata_o(xdata), .arow_i(acc_row_i), .adata_o(adata)
  );

  // Pending transfer waits for an empty register and no fill
  assign load = pend_q && shift_empty_o && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      prow_q <= '0;
    end else if (load) begin
      pend_q <= 1'b0;
    end else if (xfer_req_i && !pend_q) begin
      pend_q <= 1'b1;
      prow_q <= xfer_row_i;
    end
  end

  fb_shift_out #(.COLS(COLS)) u_shift (
    .clk_i, .rst_ni, .load_i(load), .row_i(xdata), .shift_i(shift_en_i),
    .empty_o(shift_empty_o), .bit_o(video_o)
  );

  assign rd_acc = acc_en_i && !acc_we_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_rdata_o <= 1'b0;
    else if (rd_acc) acc_rdata_o <= adata[acc_col_i];
  end
endmodule

// File: rtl/fb_video_buf_chk.sv
module fb_video_buf_chk #(
  parameter int unsigned RW = 8,
  parameter int unsigned CW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          acc_en_i,
  input logic          acc_we_i,
  input logic          acc_rdata_o,
  input logic          fill_start_i,
  input logic [RW-1:0] fill_row0_i,
  input logic [RW-1:0] fill_row1_i,
  input logic [CW-1:0] fill_col0_i,
  input logic [CW-1:0] fill_col1_i,
  input logic          busy_o,
  input logic          shift_empty_o,
  input logic          video_o,
  input logic          load
);
  logic          good_rng;
  logic [RW:0]   exp_len, run_len;

  assign good_rng = (fill_row0_i <= fill_row1_i) && (fill_col0_i <= fill_col1_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_len <= '0;
      run_len <= '0;
    end else if (fill_start_i && !busy_o && good_rng) begin
      exp_len <= (RW+1)'(fill_row1_i) - (RW+1)'(fill_row0_i) + 1'b1;
      run_len <= '0;
    end else if (busy_o) begin
      run_len <= run_len + 1'b1;
    end
  end

  p_rdata_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_en_i && !acc_we_i && !busy_o) |=> $stable(acc_rdata_o));
  p_load_fills_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> !shift_empty_o);
  p_video_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_empty_o |-> !video_o);
  p_load_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |-> (shift_empty_o && !busy_o));
  p_fill_begins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_start_i && !busy_o && good_rng) |=> busy_o);
  p_fill_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_len == exp_len));
  p_bad_rect_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_start_i && !busy_o && !good_rng) |=> !busy_o);
endmodule

bind fb_video_buf fb_video_buf_chk #(.RW(RW), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .acc_en_i(acc_en_i), .acc_we_i(acc_we_i),
  .acc_rdata_o(acc_rdata_o), .fill_start_i(fill_start_i),
  .fill_row0_i(fill_row0_i), .fill_row1_i(fill_row1_i),
  .fill_col0_i(fill_col0_i), .fill_col1_i(fill_col1_i),
  .busy_o(busy_o), .shift_empty_o(shift_empty_o), .video_o(video_o), .load(load)
);

// File: tb/tb_fb_video_buf.sv
module tb_fb_video_buf;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       acc_en = 0, acc_we = 0, acc_wdata = 0;
  logic [7:0] acc_row = 0, acc_col = 0;
  logic       fill_start = 0, fill_val = 0;
  logic [7:0] f_r0 = 0, f_r1 = 0, f_c0 = 0, f_c1 = 0;
  logic       xfer_req = 0, shift_en = 0;
  logic [7:0] xfer_row = 0;
  logic       rdata, busy, empty, video;

  int vectors = 0, misses = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fb_video_buf dut (
    .clk_i(clk), .rst_ni(rst_n),
    .acc_en_i(acc_en), .acc_we_i(acc_we), .acc_row_i(acc_row), .acc_col_i(acc_col),
    .acc_wdata_i(acc_wdata), .acc_rdata_o(rdata),
    .fill_start_i(fill_start), .fill_row0_i(f_r0), .fill_row1_i(f_r1),
    .fill_col0_i(f_c0), .fill_col1_i(f_c1), .fill_val_i(fill_val), .busy_o(busy),
    .xfer_req_i(xfer_req), .xfer_row_i(xfer_row), .shift_en_i(shift_en),
    .shift_empty_o(empty), .video_o(video)
  );

  // Behavioural reference model
  logic [255:0] m_mem [256];
  bit   m_q [$];
  bit   m_busy, m_val, m_pend, m_rd;
  int   m_frow, m_r1, m_c0, m_c1, m_prow;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q.delete(); m_busy = 0; m_pend = 0; m_rd = 0;
    end else begin
      bit ob, oe, ld;
      logic [255:0] snap;
      ob = m_busy; oe = (m_q.size() == 0);
      ld = m_pend && oe && !ob;
      snap = m_mem[m_prow];
      if (!oe && shift_en) void'(m_q.pop_front());
      if (ld) begin
        for (int c = 0; c < 256; c++) m_q.push_back(snap[c]);
        m_pend = 0;
      end else if (xfer_req && !m_pend) begin
        m_pend = 1; m_prow = xfer_row;
      end
      if (!ob && acc_en) begin
        if (acc_we) m_mem[acc_row][acc_col] = acc_wdata;
        else        m_rd = m_mem[acc_row][acc_col];
      end
      if (ob) begin
        for (int c = m_c0; c <= m_c1; c++) m_mem[m_frow][c] = m_val;
        if (m_frow == m_r1) m_busy = 0; else m_frow++;
      end else if (fill_start && f_r0 <= f_r1 && f_c0 <= f_c1) begin
        m_busy = 1; m_frow = f_r0; m_r1 = f_r1; m_c0 = f_c0; m_c1 = f_c1; m_val = fill_val;
      end
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    chk("R7 busy", busy, m_busy);
    chk("R3 empty", empty, m_q.size() == 0);
    chk("R2 video", video, (m_q.size() == 0) ? 1'b0 : m_q[0]);
    chk("R1 rdata", rdata, m_rd);
  end

  task automatic wr(int r, int c, bit v);
    @(negedge clk); acc_en = 1; acc_we = 1; acc_row = r[7:0]; acc_col = c[7:0]; acc_wdata = v;
    @(negedge clk); acc_en = 0; acc_we = 0;
  endtask

  task automatic rd(int r, int c, string tag, bit exp);
    @(negedge clk); acc_en = 1; acc_we = 0; acc_row = r[7:0]; acc_col = c[7:0];
    @(negedge clk); acc_en = 0;
    chk(tag, rdata, exp);
  endtask

  task automatic fill(int r0, int r1, int c0, int c1, bit v);
    @(negedge clk); fill_start = 1; f_r0 = r0[7:0]; f_r1 = r1[7:0];
    f_c0 = c0[7:0]; f_c1 = c1[7:0]; fill_val = v;
    @(negedge clk); fill_start = 0;
  endtask

  task automatic req(int r);
    @(negedge clk); xfer_req = 1; xfer_row = r[7:0];
    @(negedge clk); xfer_req = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    misses++;
    $display("FAIL watchdog: actual hung expected done");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 busy", busy, 0); chk("R10 empty", empty, 1);
    chk("R10 video", video, 0); chk("R10 rdata", rdata, 0);
    rst_n = 1;

    // Whole-frame clear; R8 ignored accesses during busy
    fill(0, 255, 0, 255, 0);
    wr(5, 5, 1);
    fill(2, 3, 0, 255, 1);
    wait_idle();
    rd(5, 5, "R8 write ignored", 0);
    rd(2, 100, "R8 fill start ignored", 0);

    // R1 random write/read
    wr(7, 0, 1); wr(7, 255, 1); wr(200, 128, 1);
    rd(7, 0, "R1", 1); rd(7, 255, "R1", 1); rd(7, 1, "R1", 0); rd(200, 128, "R1", 1);
    wr(7, 0, 0); rd(7, 0, "R1", 0);

    // R6 rectangle fill, corners and neighbours
    fill(10, 13, 3, 200, 1);
    chk("R7 busy rises", busy, 1);
    wait_idle();
    rd(10, 3, "R6", 1); rd(13, 200, "R6", 1); rd(10, 2, "R6", 0);
    rd(13, 201, "R6", 0); rd(9, 50, "R6", 0); rd(14, 50, "R6", 0);
    fill(11, 11, 50, 60, 0);
    wait_idle();
    rd(11, 55, "R6", 0); rd(11, 61, "R6", 1);

    // R9 bad bounds
    fill(30, 20, 0, 255, 1);
    chk("R9 no busy", busy, 0);
    fill(20, 30, 9, 8, 1);
    chk("R9 no busy", busy, 0);
    rd(25, 8, "R9", 0);

    // R2/R5/R4 stream row 10 with gaps and overwrites
    wr(10, 100, 1);
    req(10);
    @(negedge clk);
    chk("R2 loaded", empty, 0);
    wr(10, 3, 0); wr(10, 150, 0);
    req(11);
    req(0);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk); shift_en = (i % 3 != 2);
      chk("R5 video", video, (m_q.size() == 0) ? 1'b0 : m_q[0]);
      if (i % 3 == 2) begin
        shift_en = 0;
      end
    end
    @(negedge clk); shift_en = 1;
    while (m_q.size() != 0 && m_q.size() != 256) @(negedge clk);
    shift_en = 0;
    @(negedge clk);
    // R4 queued row 11 loaded after drain; row 0 request was dropped
    chk("R4 row 11 loaded", empty, 0);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk); shift_en = 1;
    end
    @(negedge clk); shift_en = 0;
    repeat (2) @(negedge clk);
    chk("R3 drained", empty, 1);
    chk("R4 dropped request", empty, 1);

    // R8 transfer stalls behind a fill
    fill(40, 47, 0, 255, 1);
    req(40);
    chk("R8 stalled", empty, 1);
    wait_idle();
    @(negedge clk);
    chk("R8 load after fill", empty, 0);
    chk("R2 first column", video, 1);
    repeat (256) begin
      @(negedge clk); shift_en = 1;
    end
    @(negedge clk); shift_en = 0;
    repeat (2) @(negedge clk);
    chk("R3 empty end", empty, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule